// File: doc/BRIEF.md
# Level-Sensitive Shift-Register Latch Chain

This block is a chain of shift-register latch cells for logic built on level-sensitive storage instead of edge-triggered flip-flops. Every cell holds two storage elements. The front element takes the cell's system data while the capture clock is high. It takes the cell's scan input while the scan-master clock is high. The back element copies the front element while the scan-slave clock is high. The back element of each cell drives the scan input of the next cell. The last back element is the scan output.

In functional use both scan clocks stay low and data is captured with the capture clock. In the double-latch arrangement the system output of a cell is read from its back element. To test, the capture clock stays low and the two scan clocks are pulsed in turn: a master pulse, then a slave pulse. Each such pair moves the chain by one bit. The capture/slave and master/slave clock pairs must never be high together. A sticky violation output records any such overlap. A separate sticky flag records the undefined case where capture and master are both high.

The design is FPGA-minded. Each level-sensitive element is emulated by a register clocked by a fast system clock. The three phase clocks act as level enables, sampled on each rising edge of that clock. An element that is enabled in a cycle takes its source value at that edge.

Top module: `lssd_chain`

## Requirements
- R1: A synchronous active-high reset clears every front and back element, the scan output, the violation output and the conflict flag to 0.
- R2: With the capture clock high and the master clock low, every front element `front_q[i]` takes `sys_d[i]` at the next edge.
- R3: With both the capture and master clocks low, no front element changes.
- R4: With the master clock high and the capture clock low, front element 0 takes `scan_in` and front element i takes back element i-1, at the next edge.
- R5: With the slave clock high, every back element takes the value its front element held before that edge. With the slave clock low, no back element changes.
- R6: A master pulse followed by a slave pulse moves the chain by one position. After CELLS such pairs, the bit shifted in first appears on `scan_out`, which always equals back element CELLS-1.
- R7: With the capture and master clocks both high, the front elements hold their value and `capture_conflict` is set.
- R8: `overlap_err` is set one edge after the capture and slave clocks, or the master and slave clocks, are sampled high together. The conflict of R7 alone does not set it.
- R9: `overlap_err` and `capture_conflict` stay set until reset, whatever the clocks do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock sampling the phase clocks |
| rst | input | 1 | Synchronous active-high reset |
| phase_c | input | 1 | Capture clock (system data into front elements) |
| phase_a | input | 1 | Scan-master clock (scan input into front elements) |
| phase_b | input | 1 | Scan-slave clock (front into back elements) |
| sys_d | input | CELLS | Per-cell system data |
| scan_in | input | 1 | Serial input to cell 0 |
| front_q | output | CELLS | Front element of each cell |
| back_q | output | CELLS | Back element of each cell, the double-latch system output |
| scan_out | output | 1 | Back element of the last cell |
| overlap_err | output | 1 | Sticky forbidden-pair violation |
| capture_conflict | output | 1 | Sticky capture/master conflict |

## Verification
Two pairs of functions can fall in the same cycle. One is a front-element load together with a back-element copy, under a forbidden overlap. The other is a capture together with a scan load. The bench drives capture-with-slave and master-with-slave in single cycles. It checks that the back elements take the pre-edge front values, that the front elements follow their own rule, and that only the violation output rises. It also drives capture-with-master and checks that the front elements hold and that only the conflict flag rises. A reference model in the bench, built from the requirements, judges every element after every step.

// File: rtl/lssd_pkg.sv
package lssd_pkg;

  typedef enum logic [1:0] {
    FRONT_HOLD    = 2'd0,
    FRONT_CAPTURE = 2'd1,
    FRONT_SCAN    = 2'd2
  } front_sel_t;

  function automatic front_sel_t front_select(input logic c, input logic a);
    if (c && !a)      return FRONT_CAPTURE;
    else if (a && !c) return FRONT_SCAN;
    else              return FRONT_HOLD;
  endfunction

endpackage

// File: rtl/lssd_cell.sv
module lssd_cell
  import lssd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic phase_c,
  input  logic phase_a,
  input  logic phase_b,
  input  logic data_in,
  input  logic chain_in,
  output logic front_q,
  output logic back_q
);

  front_sel_t sel;
  logic       front_next;

  always_comb begin
    sel = front_select(phase_c, phase_a);
    unique case (sel)
      FRONT_CAPTURE: front_next = data_in;
      FRONT_SCAN:    front_next = chain_in;
      default:       front_next = front_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      front_q <= 1'b0;
      back_q  <= 1'b0;
    end else begin
      front_q <= front_next;
      if (phase_b) back_q <= front_q;
    end
  end

  AST_FRONT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (phase_c && !phase_a) |=> (front_q == $past(data_in))); // R2
  AST_FRONT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!phase_c && !phase_a) |=> $stable(front_q)); // R3
  AST_FRONT_SCAN: assert property (@(posedge clk) disable iff (rst)
    (phase_a && !phase_c) |=> (front_q == $past(chain_in))); // R4
  AST_BACK_COPY: assert property (@(posedge clk) disable iff (rst)
    phase_b |=> (back_q == $past(front_q))); // R5
  AST_BACK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !phase_b |=> $stable(back_q)); // R5
  AST_CONFLICT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (phase_c && phase_a) |=> $stable(front_q)); // R7

endmodule

// File: rtl/lssd_overlap_mon.sv
module lssd_overlap_mon (
  input  logic clk,
  input  logic rst,
  input  logic phase_c,
  input  logic phase_a,
  input  logic phase_b,
  output logic overlap_err,
  output logic capture_conflict
);

  logic forbidden_pair;
  logic undefined_pair;

  always_comb begin
    forbidden_pair = phase_b && (phase_c || phase_a);
    undefined_pair = phase_c && phase_a;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      overlap_err      <= 1'b0;
      capture_conflict <= 1'b0;
    end else begin
      if (forbidden_pair) overlap_err      <= 1'b1;
      if (undefined_pair) capture_conflict <= 1'b1;
    end
  end

  AST_OVERLAP_SET: assert property (@(posedge clk) disable iff (rst)
    ((phase_c && phase_b) || (phase_a && phase_b)) |=> overlap_err); // R8
  AST_OVERLAP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!overlap_err && !phase_b) |=> !overlap_err); // R8
  AST_OVERLAP_STICKY: assert property (@(posedge clk) disable iff (rst)
    overlap_err |=> overlap_err); // R9
  AST_CONFLICT_SET: assert property (@(posedge clk) disable iff (rst)
    (phase_c && phase_a) |=> capture_conflict); // R7
  AST_CONFLICT_STICKY: assert property (@(posedge clk) disable iff (rst)
    capture_conflict |=> capture_conflict); // R9

endmodule

// File: rtl/lssd_chain.sv
module lssd_chain #(
  parameter int CELLS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             phase_c,
  input  logic             phase_a,
  input  logic             phase_b,
  input  logic [CELLS-1:0] sys_d,
  input  logic             scan_in,
  output logic [CELLS-1:0] front_q,
  output logic [CELLS-1:0] back_q,
  output logic             scan_out,
  output logic             overlap_err,
  output logic             capture_conflict
);

  localparam int LAST = CELLS - 1;

  logic [CELLS-1:0] chain_src;

  generate
    for (genvar i = 0; i < CELLS; i++) begin : g_cell
      if (i == 0) begin : g_head
        assign chain_src[i] = scan_in;
      end else begin : g_link
        assign chain_src[i] = back_q[i-1];
      end

      lssd_cell u_cell (
        .clk      (clk),
        .rst      (rst),
        .phase_c  (phase_c),
        .phase_a  (phase_a),
        .phase_b  (phase_b),
        .data_in  (sys_d[i]),
        .chain_in (chain_src[i]),
        .front_q  (front_q[i]),
        .back_q   (back_q[i])
      );
    end
  endgenerate

  assign scan_out = back_q[LAST];

  lssd_overlap_mon u_mon (
    .clk              (clk),
    .rst              (rst),
    .phase_c          (phase_c),
    .phase_a          (phase_a),
    .phase_b          (phase_b),
    .overlap_err      (overlap_err),
    .capture_conflict (capture_conflict)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (front_q == '0 && back_q == '0 && !overlap_err && !capture_conflict)); // R1
  AST_HEAD_SCAN: assert property (@(posedge clk) disable iff (rst)
    (phase_a && !phase_c) |=> (front_q[0] == $past(scan_in))); // R4
  AST_SCAN_OUT_TAIL: assert property (@(posedge clk) disable iff (rst)
    (phase_b && !phase_c) |=> (scan_out == $past(front_q[LAST]))); // R6

endmodule

// File: tb/lssd_chain_tb.sv
module lssd_chain_tb_top;

  localparam int CELLS = 8;

  logic             clk = 1'b0;
  logic             rst;
  logic             phase_c, phase_a, phase_b;
  logic [CELLS-1:0] sys_d;
  logic             scan_in;
  logic [CELLS-1:0] front_q, back_q;
  logic             scan_out, overlap_err, capture_conflict;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [CELLS-1:0] em_front, em_back;
  logic             em_ovl, em_cf;

  always #10 clk = ~clk;

  lssd_chain #(.CELLS(CELLS)) dut_i (
    .clk(clk), .rst(rst), .phase_c(phase_c), .phase_a(phase_a), .phase_b(phase_b),
    .sys_d(sys_d), .scan_in(scan_in), .front_q(front_q), .back_q(back_q),
    .scan_out(scan_out), .overlap_err(overlap_err), .capture_conflict(capture_conflict)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "front_q", 32'(front_q), 32'(em_front));
    chk(tag, "back_q", 32'(back_q), 32'(em_back));
    chk(tag, "scan_out", 32'(scan_out), 32'(em_back[CELLS-1]));
    chk(tag, "overlap_err", 32'(overlap_err), 32'(em_ovl));
    chk(tag, "capture_conflict", 32'(capture_conflict), 32'(em_cf));
  endtask

  // One clock step with the given phase levels, then compare with the model.
  task automatic step(input logic c, input logic a, input logic b, input string tag);
    logic [CELLS-1:0] src;
    logic [CELLS-1:0] old_front;
    phase_c = c; phase_a = a; phase_b = b;
    src       = {em_back[CELLS-2:0], scan_in};
    old_front = em_front;
    if (c && !a)      em_front = sys_d;
    else if (a && !c) em_front = src;
    if (b) em_back = old_front;
    if (b && (c || a)) em_ovl = 1'b1;
    if (c && a)        em_cf  = 1'b1;
    @(negedge clk);
    phase_c = 1'b0; phase_a = 1'b0; phase_b = 1'b0;
    compare_all(tag);
  endtask

  task automatic do_reset();
    rst = 1'b1; phase_c = 0; phase_a = 0; phase_b = 0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    em_front = '0; em_back = '0; em_ovl = 0; em_cf = 0;
    compare_all("R1");
  endtask

  task automatic t_reset_state();
    sys_d = 8'hFF; scan_in = 1'b1;
    do_reset();
  endtask

  task automatic t_capture_and_copy();
    sys_d = 8'hA5;
    step(1, 0, 0, "R2");
    sys_d = 8'h3C;
    step(0, 0, 0, "R3");
    step(0, 0, 0, "R3");
    step(0, 0, 1, "R5");
    chk("R5", "double-latch output", 32'(back_q), 32'h000000A5);
    sys_d = 8'h5A;
    step(1, 0, 0, "R2");
    chk("R5", "back held while slave low", 32'(back_q), 32'h000000A5);
  endtask

  task automatic t_scan_shift();
    logic [CELLS-1:0] pattern = 8'h96;
    logic [CELLS-1:0] seen;
    // load a known image, then shift it out while shifting the pattern in
    sys_d = 8'hC3;
    step(1, 0, 0, "R2");
    step(0, 0, 1, "R5");
    for (int k = 0; k < CELLS; k++) begin
      chk("R6", "scan_out before pair", 32'(scan_out), 32'((8'hC3 >> (CELLS-1-k)) & 1));
      scan_in = pattern[k];
      step(0, 1, 0, "R4");
      step(0, 0, 1, "R6");
    end
    for (int k = 0; k < CELLS; k++) seen[CELLS-1-k] = pattern[k];
    chk("R6", "chain image after CELLS pairs", 32'(back_q), 32'(seen));
    chk("R6", "first bit at scan_out", 32'(scan_out), 32'(pattern[0]));
  endtask

  task automatic t_conflict();
    sys_d = ~front_q; scan_in = ~front_q[0];
    step(1, 1, 0, "R7");
    chk("R7", "overlap untouched", 32'(overlap_err), 32'h0);
    step(0, 0, 0, "R9");
    step(0, 1, 0, "R9");
    chk("R9", "conflict still set", 32'(capture_conflict), 32'h1);
  endtask

  task automatic t_overlap_cb();
    do_reset();
    sys_d = 8'h0F;
    step(1, 0, 0, "R2");
    sys_d = 8'hF0;
    step(1, 0, 1, "R8");
    chk("R8", "conflict untouched", 32'(capture_conflict), 32'h0);
    step(0, 0, 0, "R9");
    step(0, 0, 0, "R9");
  endtask

  task automatic t_overlap_ab();
    do_reset();
    sys_d = 8'h81;
    step(1, 0, 0, "R2");
    scan_in = 1'b0;
    step(0, 1, 1, "R8");
    step(0, 0, 1, "R9");
    do_reset();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; phase_c = 0; phase_a = 0; phase_b = 0; sys_d = '0; scan_in = 0;
    @(negedge clk);
    t_reset_state();
    t_capture_and_copy();
    t_scan_shift();
    t_conflict();
    t_overlap_cb();
    t_overlap_ab();
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule